// File: doc/BRIEF.md
# Encoded-Ratio Clock Post-Divider Bank

This block derives up to ten gated clocks from one reference clock. The lanes are split into two banks of five, and each bank has its own divider. A bank's ratio comes from a 4-bit select code that maps to a small, uneven set of ratios. The set includes the odd ratio 5 and tops out at 80.

Configuration arrives as static register bits: a select code and an enable per bank, an enable per lane, and one global enable. A new select code takes effect at the next reference edge. There is no wait for a common phase point, so the two banks may end up with any phase relation after a change. A lane that is switched off rests at a static high level, which models a pulled-up output. The global enable switches every lane off and freezes both dividers.

Top module: `pdiv_bank_top`

## Requirements
- R1: A bank's 4-bit select code picks its ratio. Codes 0 to 10 give 1, 2, 4, 5, 8, 10, 16, 20, 32, 40 and 80 in that order. Bank b reads its code from `bank_sel_i[4*b+3:4*b]`.
- R2: After a synchronous active-low reset, both banks divide by 1.
- R3: With an even ratio N, a lane is high for N/2 reference cycles and low for N/2 reference cycles.
- R4: With ratio 5, a lane is high for 2 reference cycles and low for 3.
- R5: Select codes 11 to 15 are invalid. A bank that sees one keeps its last valid ratio.
- R6: With `bank_en_i[0]` at 0, lanes 0 to 4 sit at static 1. With `bank_en_i[1]` at 0, lanes 5 to 9 sit at static 1. The other bank keeps running.
- R7: With `lane_en_i[k]` at 0, only lane k sits at static 1. Every other lane keeps its waveform without disturbance.
- R8: With `chip_en_i` at 0, every lane sits at static 1 and both divider counters hold their value.
- R9: A new select code acts from the next reference edge, with no wait for phase alignment. Changing one bank does not disturb the other bank's waveform.
- R10: At ratio 1, an enabled lane follows the reference clock directly: high while the reference is high and low while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| chip_en_i | input | 1 | Global enable; 0 switches off every lane and freezes the dividers |
| bank_en_i | input | NUM_BANKS | Per-bank enable |
| bank_sel_i | input | NUM_BANKS*4 | Per-bank ratio select codes, bank b at bits 4b+3..4b |
| lane_en_i | input | NUM_BANKS*LANES_PER_BANK | Per-lane enable |
| clk_o | output | NUM_BANKS*LANES_PER_BANK | Gated divided clocks; static 1 when switched off |

## Verification
A wrong held ratio or counter value shows as the wrong high or low run length on every lane of that bank. It becomes visible within one output period, at most 80 reference cycles. A counter that is left out of range after a ratio change would delay the new waveform beyond the first few edges, so the bench times the first new period right after a switch. Cross-bank disturbance would break the periodicity of the untouched bank's lane within the same window. The bench checks that periodicity sample by sample.

// File: rtl/pdiv_pkg.sv
// Package: shared widths and the select-code decode for the post-divider.
// Assumes ratios never exceed MAX_RATIO.
package pdiv_pkg;
    localparam int SEL_W     = 4;
    localparam int MAX_RATIO = 80;
    localparam int RATIO_W   = $clog2(MAX_RATIO + 1);

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        logic   valid;
        ratio_t ratio;
    } decode_t;

    // Map a select code to its ratio; codes above 10 are flagged invalid.
    function automatic decode_t decode_sel(input logic [SEL_W-1:0] code);
        decode_t d;
        d.valid = 1'b1;
        case (code)
            4'd0:    d.ratio = ratio_t'(1);
            4'd1:    d.ratio = ratio_t'(2);
            4'd2:    d.ratio = ratio_t'(4);
            4'd3:    d.ratio = ratio_t'(5);
            4'd4:    d.ratio = ratio_t'(8);
            4'd5:    d.ratio = ratio_t'(10);
            4'd6:    d.ratio = ratio_t'(16);
            4'd7:    d.ratio = ratio_t'(20);
            4'd8:    d.ratio = ratio_t'(32);
            4'd9:    d.ratio = ratio_t'(40);
            4'd10:   d.ratio = ratio_t'(80);
            default: begin
                d.valid = 1'b0;
                d.ratio = ratio_t'(1);
            end
        endcase
        return d;
    endfunction
endpackage

// File: rtl/pdiv_ratio_hold.sv
// Module: registers a bank's ratio from its select code.
// Keeps the previous ratio whenever the code is invalid. Resets to ratio 1.
module pdiv_ratio_hold
    import pdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] sel_i,
    output ratio_t           ratio_o
);
    decode_t dec;
    ratio_t  ratio_q;

    // Decode the incoming code.
    always_comb dec = decode_sel(sel_i);

    // Load a valid ratio; hold on an invalid code.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        ratio_q <= ratio_t'(1);
        else if (dec.valid) ratio_q <= dec.ratio;
    end

    assign ratio_o = ratio_q;

    // R2: the first cycle out of reset shows ratio 1.
    a_r2_reset_ratio_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!rst_ni) |-> ratio_q == ratio_t'(1));

    // R5: an invalid code leaves the ratio untouched.
    a_r5_hold_on_bad_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dec.valid && $past(rst_ni)) |=> $stable(ratio_q));
endmodule

// File: rtl/pdiv_divider.sv
// Module: integer divider producing the bank's source clock.
// The high time is floor(N/2) cycles and the low time is the rest.
// Ratio 1 bypasses the counter and passes the reference through.
// A ratio change acts at once: an out-of-range count wraps to 0.
module pdiv_divider
    import pdiv_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   run_i,
    input  ratio_t ratio_i,
    output logic   src_o
);
    ratio_t cnt_q, cnt_next, half;
    logic   div_q;

    // Next count, wrapping at the current ratio.
    always_comb begin
        half     = ratio_i >> 1;
        cnt_next = (cnt_q >= ratio_i - ratio_t'(1)) ? '0 : cnt_q + ratio_t'(1);
    end

    // Advance the counter and the registered phase while running.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            div_q <= 1'b0;
        end else if (run_i) begin
            cnt_q <= cnt_next;
            div_q <= (cnt_next < half);
        end
    end

    // Choose the reference itself for ratio 1, else the divided phase.
    always_comb src_o = (ratio_i == ratio_t'(1)) ? clk_i : div_q;

    // R9: after a running edge the count is below the ratio in force then.
    a_r9_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |=> cnt_q < $past(ratio_i));

    // R8: a stopped divider keeps its count.
    a_r8_counter_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && $past(rst_ni)) |=> $stable(cnt_q));
endmodule

// File: rtl/pdiv_lane_gate.sv
// Module: one output lane. Passes the bank source when enabled.
// Otherwise it rests at 1, modelling a pulled-up output.
module pdiv_lane_gate (
    input  logic chip_en_i,
    input  logic bank_en_i,
    input  logic lane_en_i,
    input  logic src_i,
    output logic out_o
);
    logic open_q;

    // Combine the three enables for this lane.
    always_comb open_q = chip_en_i & bank_en_i & lane_en_i;

    // Drive the source or the resting high level.
    always_comb out_o = open_q ? src_i : 1'b1;

    // R7: a lane that is switched off never shows a low level.
    always_comb begin
        if (!lane_en_i) a_r7_lane_off_high: assert (out_o == 1'b1);
    end
endmodule

// File: rtl/pdiv_bank_top.sv
// Module: the two-bank post-divider. Each bank holds a ratio and runs a
// divider, and each bank feeds LANES_PER_BANK gated lanes.
// Configuration inputs are assumed static between changes.
module pdiv_bank_top
    import pdiv_pkg::*;
#(
    parameter int NUM_BANKS      = 2,
    parameter int LANES_PER_BANK = 5,
    localparam int NUM_LANES     = NUM_BANKS * LANES_PER_BANK
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       chip_en_i,
    input  logic [NUM_BANKS-1:0]       bank_en_i,
    input  logic [NUM_BANKS*SEL_W-1:0] bank_sel_i,
    input  logic [NUM_LANES-1:0]       lane_en_i,
    output logic [NUM_LANES-1:0]       clk_o
);
    logic [NUM_BANKS-1:0] bank_src;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ratio_t ratio;

        pdiv_ratio_hold u_hold (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .sel_i   (bank_sel_i[b*SEL_W +: SEL_W]),
            .ratio_o (ratio)
        );

        pdiv_divider u_div (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .run_i   (chip_en_i),
            .ratio_i (ratio),
            .src_o   (bank_src[b])
        );

        for (genvar l = 0; l < LANES_PER_BANK; l++) begin : g_lane
            pdiv_lane_gate u_gate (
                .chip_en_i (chip_en_i),
                .bank_en_i (bank_en_i[b]),
                .lane_en_i (lane_en_i[b*LANES_PER_BANK + l]),
                .src_i     (bank_src[b]),
                .out_o     (clk_o[b*LANES_PER_BANK + l])
            );
        end
    end

    // R8: with the chip switched off, every lane rests high after each edge.
    a_r8_all_lanes_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !chip_en_i |-> (&clk_o));
endmodule

// File: tb/test_pdiv_bank_top.sv
module test_pdiv_bank_top;
    localparam int NL = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          chip_en;
    logic [1:0]    bank_en;
    logic [7:0]    bank_sel;
    logic [NL-1:0] lane_en;
    logic [NL-1:0] clk_out;
    logic [NL-1:0] s;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    pdiv_bank_top i_pdiv_bank_top (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .chip_en_i  (chip_en),
        .bank_en_i  (bank_en),
        .bank_sel_i (bank_sel),
        .lane_en_i  (lane_en),
        .clk_o      (clk_out)
    );

    always #5 clk = ~clk;

    function automatic int exp_ratio(input int c);
        case (c)
            0: return 1;   1: return 2;   2: return 4;   3: return 5;
            4: return 8;   5: return 10;  6: return 16;  7: return 20;
            8: return 32;  9: return 40;  10: return 80;
            default: return -1;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One reference cycle; sample 2 ns after the rising edge.
    task automatic tick();
        @(posedge clk);
        #2;
        s = clk_out;
    endtask

    // Measure one full high run and the following low run on a lane.
    task automatic measure(input int lane, output int hi, output int lo);
        int n = 0;
        hi = 0; lo = 0;
        while (s[lane] !== 1'b0 && n < 200) begin tick(); n++; end
        while (s[lane] !== 1'b1 && n < 400) begin tick(); n++; end
        while (s[lane] === 1'b1 && n < 600) begin hi++; tick(); n++; end
        while (s[lane] === 1'b0 && n < 800) begin lo++; tick(); n++; end
    endtask

    // Check that a lane follows the reference in both clock phases.
    task automatic check_follow(input string req, input int lane);
        tick();
        check(req, int'(clk_out[lane]), 1);
        #5;
        check(req, int'(clk_out[lane]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int hi, lo, n;
        logic [39:0] win;
        rst_n = 0; chip_en = 1; bank_en = 2'b11; bank_sel = 8'h00; lane_en = '1;
        repeat (4) tick();
        rst_n = 1;

        // R2 / R10: ratio 1 after reset, every lane follows the reference.
        for (int l = 0; l < NL; l++) check_follow("R2_R10 reset passthrough", l);

        // R1 / R3 / R4 / R10: sweep every code on both banks.
        for (int c = 0; c <= 10; c++) begin
            bank_sel = {4'(10 - c), 4'(c)};
            repeat (170) tick();
            if (c == 0) check_follow("R10 bank0 ratio1", 0);
            else begin
                measure(0, hi, lo);
                check("R1_R3_R4 bank0 high", hi, exp_ratio(c) / 2);
                check("R1_R3_R4 bank0 low", lo, exp_ratio(c) - exp_ratio(c) / 2);
            end
            if (c == 10) check_follow("R10 bank1 ratio1", 7);
            else begin
                measure(7, hi, lo);
                check("R1_R3 bank1 high", hi, exp_ratio(10 - c) / 2);
                check("R1_R3 bank1 low", lo, exp_ratio(10 - c) - exp_ratio(10 - c) / 2);
            end
        end

        // R9: ratio 80 to ratio 2 acts within a few edges.
        bank_sel = {4'd2, 4'd10};
        repeat (30) tick();
        bank_sel[3:0] = 4'd1;
        n = 0;
        tick();
        while (n < 6) begin tick(); n++; end
        measure(0, hi, lo);
        check("R9 immediate high", hi, 1);
        check("R9 immediate low", lo, 1);

        // R9: bank1 (ratio 4) stays periodic across a bank0 change.
        for (int i = 0; i < 40; i++) begin
            if (i == 20) bank_sel[3:0] = 4'd3;
            tick();
            win[i] = s[6];
        end
        n = 0;
        for (int i = 4; i < 40; i++) if (win[i] != win[i-4]) n++;
        check("R9 other bank undisturbed", n, 0);

        // R5: invalid codes keep ratio 5.
        for (int bad = 11; bad <= 15; bad++) begin
            bank_sel[3:0] = 4'(bad);
            repeat (20) tick();
            measure(0, hi, lo);
            check("R5 hold high", hi, 2);
            check("R5 hold low", lo, 3);
        end
        bank_sel[3:0] = 4'd1;
        repeat (10) tick();

        // R6: each bank enable silences only its own five lanes.
        for (int b = 0; b < 2; b++) begin
            logic [NL-1:0] andv, orv;
            bank_en = ~(2'b01 << b);
            andv = '1; orv = '0;
            repeat (2) tick();
            for (int i = 0; i < 20; i++) begin tick(); andv &= s; orv |= ~s; end
            for (int l = 0; l < NL; l++)
                if (l / 5 == b) check("R6 disabled bank lane high", int'(andv[l]), 1);
                else            check("R6 other bank toggles", int'(orv[l]), 1);
            bank_en = 2'b11;
        end

        // R7: one lane disabled at a time; its neighbours keep toggling.
        for (int k = 0; k < NL; k++) begin
            logic [NL-1:0] andv, orv;
            lane_en = ~(10'b1 << k);
            andv = '1; orv = '0;
            repeat (2) tick();
            for (int i = 0; i < 20; i++) begin tick(); andv &= s; orv |= ~s; end
            check("R7 lane off high", int'(andv[k]), 1);
            check("R7 neighbour toggles", int'(orv[(k + 1) % NL]), 1);
            lane_en = '1;
        end

        // R8: chip off holds every lane high, including the ratio-1 bypass.
        bank_sel[3:0] = 4'd0;
        repeat (3) tick();
        chip_en = 0;
        begin
            logic [NL-1:0] andv;
            andv = '1;
            for (int i = 0; i < 20; i++) begin tick(); andv &= s; #5; andv &= clk_out; end
            check("R8 all lanes high", int'(andv), 1023);
        end
        chip_en = 1;
        repeat (3) tick();
        check_follow("R8 resume after chip on", 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule